// File: doc/BRIEF.md
# Oscillator Settling and Prescale Timer

This block holds one 13-bit counter, clocked on the falling edge of the oscillator clock, and uses it for three jobs. It times the oscillator settling window after power-on and after a wake-up from stop mode, and it keeps the bus clocks gated off until that window is over. It also acts as a prescaler: each wrap from all ones to zero makes a one-cycle tick that clocks an external watchdog. Its running count and two count-reached flags feed a reset-stretching circuit.

A STOP request clears the counter, gates the bus clocks off and freezes the count at zero. A wake event (interrupt, break or reset) restarts it. The short-recovery option is sampled on the edge that accepts the wake. When it is 1 the settling window is 32 oscillator cycles. When it is 0 the window is 4096 cycles. After power-on the long window always applies.

All control pins are plain level or pulse signals. There is no data stream, so there is no handshake.

Top module: `osc_settle_timer`

## Requirements
- R1: While `por` is high, `cnt_value` is 0, and `bus_clk_en` and `wdog_tick` are 0.
- R2: After `por` falls, `bus_clk_en` rises on the 4096th falling clock edge, whatever the value of `short_rec`.
- R3: A falling edge that samples `stop_req` high sets `cnt_value` to 0 and `bus_clk_en` to 0. Until a wake is accepted the count then stays at 0, and this also applies when the stop arrives during a settling window.
- R4: While stopped, a falling edge that samples `wake_req` high with `short_rec` = 1 starts a window. `bus_clk_en` rises on the 32nd falling edge after that edge.
- R5: The same wake with `short_rec` = 0 makes `bus_clk_en` rise on the 4096th falling edge after the accepting edge.
- R6: `short_rec` matters only on the edge that accepts a wake. Changing it later does not change the window length.
- R7: Once high, `bus_clk_en` stays high until the next stop. A `wake_req` pulse while not stopped is ignored and the count keeps advancing by one.
- R8: When `stop_req` and `wake_req` are sampled high on the same edge, the stop wins. The block stays stopped with the count at 0.
- R9: `wdog_tick` is a one-cycle pulse, high on the cycle the count has just wrapped from 8191 to 0. Consecutive pulses are 8192 cycles apart. No pulse occurs while stopped.
- R10: While not stopped, the count rises by one on every falling edge. `short_reached` is high exactly when the count is 32, and `long_reached` is high exactly when it is 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state changes on its falling edge |
| por | input | 1 | Power-on reset, active high, asynchronous |
| stop_req | input | 1 | Stop-entry pulse |
| wake_req | input | 1 | Wake event (interrupt, break or reset) |
| short_rec | input | 1 | 1 selects the 32-cycle stop recovery, 0 selects 4096 |
| bus_clk_en | output | 1 | Enable for the bus clocks |
| wdog_tick | output | 1 | Watchdog clock tick on counter wrap |
| cnt_value | output | 13 | Current count, used for reset stretching |
| short_reached | output | 1 | Count equals 32 |
| long_reached | output | 1 | Count equals 4096 |

## Verification
A phase state stuck in stop or stuck in recovery shows up at the ports at once: `cnt_value` stops moving on the next edge, or `bus_clk_en` fails to rise at the expected edge. A wrongly latched option bit changes the window from 32 to 4096 cycles, or the other way, and so misses the edge by thousands of cycles. A counter that skips or repeats values moves every later flag, enable edge and tick, so the error is visible within one window or one wrap period.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic [1:0] {
    PH_SETTLE  = 2'd0,
    PH_RUN     = 2'd1,
    PH_STOPPED = 2'd2
  } ost_phase_e;

  localparam int unsigned TERM_SHORT_IDX = 0;
  localparam int unsigned TERM_LONG_IDX  = 1;
  localparam int unsigned TERM_COUNT     = 2;
endpackage

// File: rtl/ost_prescale_cnt.sv
module ost_prescale_cnt #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             osc_clk,
  input  logic             por,
  input  logic             advance,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             wrap_tick
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  always_comb cnt_inc = cnt + CNT_W'(1);

  always_ff @(negedge osc_clk or posedge por) begin
    if (por) begin
      cnt       <= '0;
      wrap_tick <= 1'b0;
    end else begin
      wrap_tick <= advance && (cnt == ALL_ONES);
      if (clear)        cnt <= '0;
      else if (advance) cnt <= cnt_inc;
    end
  end
endmodule

// File: rtl/ost_term_match.sv
module ost_term_match #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned VALUE = 32
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] nxt,
  output logic             at_now,
  output logic             at_next
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(VALUE);

  always_comb begin
    at_now  = (cur == TERM);
    at_next = (nxt == TERM);
  end
endmodule

// File: rtl/ost_phase_ctrl.sv
module ost_phase_ctrl
  import ost_pkg::*;
(
  input  logic osc_clk,
  input  logic por,
  input  logic stop_req,
  input  logic wake_req,
  input  logic short_rec,
  input  logic short_next,
  input  logic long_next,
  output logic advance,
  output logic clear,
  output logic stopped,
  output logic bus_en
);
  ost_phase_e phase_q;
  logic       use_short_q;
  logic       term_next;

  always_comb begin
    stopped   = (phase_q == PH_STOPPED);
    advance   = !stopped && !stop_req;
    clear     = stop_req;
    term_next = use_short_q ? short_next : long_next;
  end

  always_ff @(negedge osc_clk or posedge por) begin
    if (por) begin
      phase_q     <= PH_SETTLE;
      use_short_q <= 1'b0;
      bus_en      <= 1'b0;
    end else if (stop_req) begin
      phase_q <= PH_STOPPED;
      bus_en  <= 1'b0;
    end else begin
      case (phase_q)
        PH_STOPPED: begin
          if (wake_req) begin
            phase_q     <= PH_SETTLE;
            use_short_q <= short_rec;
          end
        end
        PH_SETTLE: begin
          if (term_next) begin
            phase_q <= PH_RUN;
            bus_en  <= 1'b1;
          end
        end
        PH_RUN:  phase_q <= PH_RUN;
        default: phase_q <= PH_STOPPED;
      endcase
    end
  end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned SHORT_DLY = 32,
  parameter int unsigned LONG_DLY  = 4096
) (
  input  logic             osc_clk,
  input  logic             por,
  input  logic             stop_req,
  input  logic             wake_req,
  input  logic             short_rec,
  output logic             bus_clk_en,
  output logic             wdog_tick,
  output logic [CNT_W-1:0] cnt_value,
  output logic             short_reached,
  output logic             long_reached
);
  import ost_pkg::*;

  logic [CNT_W-1:0]      cnt_inc;
  logic                  advance;
  logic                  clear;
  logic                  stopped;
  logic [TERM_COUNT-1:0] hit_now;
  logic [TERM_COUNT-1:0] hit_nxt;

  ost_prescale_cnt #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk   (osc_clk),
    .por       (por),
    .advance   (advance),
    .clear     (clear),
    .cnt       (cnt_value),
    .cnt_inc   (cnt_inc),
    .wrap_tick (wdog_tick)
  );

  for (genvar gi = 0; gi < TERM_COUNT; gi++) begin : g_term
    localparam int unsigned TVAL = (gi == TERM_SHORT_IDX) ? SHORT_DLY : LONG_DLY;
    ost_term_match #(.CNT_W(CNT_W), .VALUE(TVAL)) u_match (
      .cur     (cnt_value),
      .nxt     (cnt_inc),
      .at_now  (hit_now[gi]),
      .at_next (hit_nxt[gi])
    );
  end

  ost_phase_ctrl u_ctrl (
    .osc_clk    (osc_clk),
    .por        (por),
    .stop_req   (stop_req),
    .wake_req   (wake_req),
    .short_rec  (short_rec),
    .short_next (hit_nxt[TERM_SHORT_IDX]),
    .long_next  (hit_nxt[TERM_LONG_IDX]),
    .advance    (advance),
    .clear      (clear),
    .stopped    (stopped),
    .bus_en     (bus_clk_en)
  );

  always_comb begin
    short_reached = hit_now[TERM_SHORT_IDX];
    long_reached  = hit_now[TERM_LONG_IDX];
  end
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned SHORT_DLY = 32,
  parameter int unsigned LONG_DLY  = 4096
) (
  input logic             osc_clk,
  input logic             por,
  input logic             stop_req,
  input logic             wake_req,
  input logic             stopped,
  input logic             bus_clk_en,
  input logic             wdog_tick,
  input logic [CNT_W-1:0] cnt_value
);
  // R3: a stop clears the count and gates the clocks off
  a_r3_stop_clears: assert property (@(negedge osc_clk) disable iff (por)
    stop_req |=> (cnt_value == '0) && !bus_clk_en && stopped);

  // R3: the count stays frozen while stopped
  a_r3_frozen: assert property (@(negedge osc_clk) disable iff (por)
    stopped |=> (cnt_value == '0));

  // R10: one step per edge while running
  a_r10_step: assert property (@(negedge osc_clk) disable iff (por)
    (!stopped && !stop_req) |=> (cnt_value == CNT_W'($past(cnt_value) + CNT_W'(1))));

  // R7: the enable holds until a stop
  a_r7_hold: assert property (@(negedge osc_clk) disable iff (por)
    (bus_clk_en && !stop_req) |=> bus_clk_en);

  // R4 and R5: the enable rises only at a terminal count
  a_r4_r5_term: assert property (@(negedge osc_clk) disable iff (por)
    $rose(bus_clk_en) |-> ((cnt_value == CNT_W'(SHORT_DLY)) || (cnt_value == CNT_W'(LONG_DLY))));

  // R9: the tick marks a fresh wrap and lasts one cycle
  a_r9_tick_wrap: assert property (@(negedge osc_clk) disable iff (por)
    wdog_tick |-> (cnt_value == '0) && !stopped);

  a_r9_tick_single: assert property (@(negedge osc_clk) disable iff (por)
    wdog_tick |=> !wdog_tick);
endmodule

bind osc_settle_timer ost_checker #(
  .CNT_W(CNT_W), .SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)
) u_chk (
  .osc_clk    (osc_clk),
  .por        (por),
  .stop_req   (stop_req),
  .wake_req   (wake_req),
  .stopped    (stopped),
  .bus_clk_en (bus_clk_en),
  .wdog_tick  (wdog_tick),
  .cnt_value  (cnt_value)
);

// File: tb/test_osc_settle_timer.sv
module test_osc_settle_timer;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        stop_req = 1'b0;
  logic        wake_req = 1'b0;
  logic        short_rec = 1'b1;
  logic        bus_clk_en;
  logic        wdog_tick;
  logic [12:0] cnt_value;
  logic        short_reached;
  logic        long_reached;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  osc_settle_timer i_osc_settle_timer (
    .osc_clk(clk), .por(por), .stop_req(stop_req), .wake_req(wake_req),
    .short_rec(short_rec), .bus_clk_en(bus_clk_en), .wdog_tick(wdog_tick),
    .cnt_value(cnt_value), .short_reached(short_reached), .long_reached(long_reached)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  // monitor side of the scoreboard: measure rise of bus enable, pop expected
  task automatic measure_rise(string req, int offset);
    int k = 0;
    int exp;
    while (!bus_clk_en && k < 10000) begin
      @(posedge clk);
      k++;
    end
    exp = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
    chk(req, k + offset, exp);
  endtask

  task automatic do_stop();
    @(posedge clk);
    stop_req = 1'b1;
    @(posedge clk);
    stop_req = 1'b0;
  endtask

  // driver: wake while stopped, push the expected window length
  task automatic do_wake(bit opt, bit flip, int exp_len, string req);
    @(posedge clk);
    short_rec = opt;
    wake_req  = 1'b1;
    exp_q.push_back(exp_len);
    @(posedge clk);
    wake_req = 1'b0;
    if (flip) short_rec = !opt;
    chk(req, bus_clk_en, 0);
    // already 1 posedge after the driving edge
    measure_rise(req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    int t1;
    int t2;
    repeat (3) @(posedge clk);
    // R1 reset state
    chk("R1 count", cnt_value, 0);
    chk("R1 bus_en", bus_clk_en, 0);
    chk("R1 tick", wdog_tick, 0);

    // R2 power-on window is long even with short option set
    @(posedge clk);
    por = 1'b0;
    exp_q.push_back(4096);
    measure_rise("R2 por window", 0);
    chk("R10 count at long", cnt_value, 4096);
    chk("R10 long_reached", long_reached, 1);
    chk("R10 short_reached low", short_reached, 0);

    // R7 wake while running is ignored
    @(posedge clk);
    c0 = cnt_value;
    wake_req = 1'b1;
    @(posedge clk);
    wake_req = 1'b0;
    chk("R7 count keeps stepping", cnt_value, c0 + 1);
    chk("R7 bus_en held", bus_clk_en, 1);
    repeat (10) @(posedge clk);
    chk("R7 bus_en still held", bus_clk_en, 1);

    // R3 stop clears and freezes
    do_stop();
    chk("R3 count cleared", cnt_value, 0);
    chk("R3 bus_en off", bus_clk_en, 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      if (cnt_value != 0 || wdog_tick) chk("R3 frozen", cnt_value, 0);
    end
    chk("R3 frozen count", cnt_value, 0);

    // R4 short window
    do_wake(1'b1, 1'b0, 32, "R4 short window");
    chk("R10 short_reached", short_reached, 1);
    chk("R10 count at short", cnt_value, 32);

    // R5 long window
    do_stop();
    do_wake(1'b0, 1'b0, 4096, "R5 long window");

    // R6 option change after wake has no effect
    do_stop();
    do_wake(1'b1, 1'b1, 32, "R6 option latched");
    do_stop();
    do_wake(1'b0, 1'b1, 4096, "R6 option latched long");

    // R8 stop and wake together: stop wins
    @(posedge clk);
    stop_req = 1'b1;
    wake_req = 1'b1;
    @(posedge clk);
    stop_req = 1'b0;
    wake_req = 1'b0;
    repeat (40) @(posedge clk);
    chk("R8 stays stopped count", cnt_value, 0);
    chk("R8 stays stopped bus_en", bus_clk_en, 0);

    // R3 stop during a settling window
    @(posedge clk);
    short_rec = 1'b0;
    wake_req = 1'b1;
    @(posedge clk);
    wake_req = 1'b0;
    repeat (100) @(posedge clk);
    chk("R10 counting in window", cnt_value, 100);
    do_stop();
    repeat (4200) @(posedge clk);
    chk("R3 aborted window count", cnt_value, 0);
    chk("R3 aborted window bus_en", bus_clk_en, 0);

    // R9 tick period
    do_wake(1'b1, 1'b0, 32, "R4 short window again");
    t1 = 0;
    while (!wdog_tick && t1 < 20000) begin
      @(posedge clk);
      t1++;
    end
    chk("R9 first tick count zero", cnt_value, 0);
    @(posedge clk);
    chk("R9 tick one cycle", wdog_tick, 0);
    t2 = 1;
    while (!wdog_tick && t2 < 20000) begin
      @(posedge clk);
      t2++;
    end
    chk("R9 tick period", t2, 8192);

    finished = 1;
    summary();
    $finish;
  end
endmodule